// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Bit Capture

This block drives the clock pin of one or two pulse-density-modulated digital microphones and collects their one-bit sample streams. It runs from a fast system clock. It divides that clock down to one of three microphone clock rates, chosen at run time, and keeps each half-period exactly equal. With the default 24 MHz system clock the rates are 1.5, 2.0 and 3.0 MHz.

Two wiring modes are available. In uniplex mode each microphone has its own data pin, and both pins are sampled at the end of the clock-low half. In multiplex mode the two microphones share data pin 0. The left bit is taken at the end of the low half and the right bit at the end of the high half. Both data pins pass through a synchronizer. The capture points are moved later by the synchronizer delay, so each captured bit equals the pin level in the system cycle just before the matching microphone clock edge. Every captured bit leaves on its channel output together with a one-cycle valid strobe.

Top module: `pdm_mic_if`

## Requirements
- R1: While rst_n_i is low, mclk_o, left_vld_o and right_vld_o are 0. This holds even when en_i is high.
- R2: rate_sel_i sets the microphone clock period in system cycles: 2'b00 gives 16, 2'b01 gives 12, 2'b10 gives 8 and 2'b11 gives 16.
- R3: At every rate, each period has a high run of exactly half the period, followed by a low run of the same length.
- R4: One cycle after en_i is sampled low, mclk_o is 0. It stays 0 and no valid strobe appears while en_i stays low.
- R5: One cycle after en_i is sampled high from the idle state, mclk_o goes high and a full period runs. The first left strobe appears exactly period+3 cycles after en_i was driven high.
- R6: In uniplex mode (mode_mux_i = 0), left comes from pdm_d0_i and right from pdm_d1_i. Both strobes appear in the same cycle, two cycles after the first high cycle of mclk_o. Each bit equals its pin level in the last low cycle before that rise.
- R7: In multiplex mode (mode_mux_i = 1), both channels come from pdm_d0_i. Left behaves as in R6. Right strobes alone, two cycles after the first low cycle of mclk_o, and carries the pin level in the last high cycle before that fall.
- R8: Each valid strobe lasts one system cycle. Each channel strobes at most once per microphone clock period.
- R9: A change of rate_sel_i in mid-period leaves the current period's high and low runs unchanged. The new rate starts with the next period.
- R10: A change of mode_mux_i takes effect at the next period boundary. In the first multiplex period after uniplex, the right bit still comes from pdm_d1_i together with left. Shared-pin right capture starts one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable for clock generation and capture |
| rate_sel_i | input | 2 | Microphone clock rate select |
| mode_mux_i | input | 1 | 0 = separate pins, 1 = shared pin |
| pdm_d0_i | input | 1 | Data pin 0 (left, or both channels in multiplex) |
| pdm_d1_i | input | 1 | Data pin 1 (right in uniplex) |
| mclk_o | output | 1 | Microphone clock pin |
| left_bit_o | output | 1 | Captured left bit |
| left_vld_o | output | 1 | One-cycle strobe for left_bit_o |
| right_bit_o | output | 1 | Captured right bit |
| right_vld_o | output | 1 | One-cycle strobe for right_bit_o |

## Verification
The bench builds the block with its defaults: dividers 16, 12 and 8 and a two-stage synchronizer. These values give three distinct half-period lengths (8, 6 and 4 cycles). They also give a capture offset of one cycle after each edge, so every strobe lands inside a period even at the fastest rate. They allow pseudo-random pin data that changes every system cycle to be traced back exactly three cycles. This makes an off-by-one in the capture point or the synchronizer depth visible in the data. The dividers are short enough for rate changes, mode changes and enable restarts to be walked through in a few hundred cycles.

// File: rtl/pdm_mic_pkg.sv
// Shared encodings for the PDM microphone interface.
// Assumes the two-bit rate code and one-bit mode code described in the brief.
package pdm_mic_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW     = 2'b00,
        RATE_MID      = 2'b01,
        RATE_FAST     = 2'b10,
        RATE_SLOW_ALT = 2'b11
    } pdm_rate_e;

    typedef enum logic {
        MODE_SPLIT  = 1'b0,
        MODE_SHARED = 1'b1
    } pdm_mode_e;

    // Capture requests issued by the clock generator to the capture stage
    typedef struct packed {
        logic left;          // take left bit from pin 0
        logic right_split;   // take right bit from pin 1 (same cycle as left)
        logic right_shared;  // take right bit from pin 0 (high-half capture)
    } pdm_cap_t;

endpackage

// File: rtl/pdm_mic_sync.sv
// Multi-stage synchronizer for the microphone data pins.
// Assumes the pins are asynchronous to clk_i; STAGES sets the depth (>= 1).
module pdm_mic_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop: register the pins once
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) stage_q <= '0;
                else          stage_q <= d_i;
            end
        end else begin : g_chain
            // Shift chain: pins enter at stage 0 and move up one stage per cycle
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) stage_q <= '0;
                else          stage_q <= {stage_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pdm_mic_clkgen.sv
// Microphone clock generator and capture scheduler.
// Counts system cycles within one microphone clock period. It drives the clock
// high for the first half and low for the second half. Rate and mode are latched
// only at the start of a period. Capture requests are issued CAP_OFS cycles after
// each edge, and only once a full period has run since enable.
// Assumes even dividers with CAP_OFS smaller than half of the fastest period.
module pdm_mic_clkgen
    import pdm_mic_pkg::*;
#(
    parameter int DIV_SLOW = 16,
    parameter int DIV_MID  = 12,
    parameter int DIV_FAST = 8,
    parameter int CAP_OFS  = 1
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       en_i,
    input  logic [1:0] rate_sel_i,
    input  logic       mode_i,
    output logic       mclk_o,
    output pdm_cap_t   cap_o
);

    localparam int MAX_AB  = (DIV_SLOW > DIV_MID) ? DIV_SLOW : DIV_MID;
    localparam int MAX_DIV = (MAX_AB > DIV_FAST) ? MAX_AB : DIV_FAST;
    localparam int CW      = $clog2(MAX_DIV);
    localparam int PW      = CW + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;      // period length minus one
    logic [CW-1:0] half_q;      // half-period length
    logic          run_q;
    logic          ran_q;       // a full period has completed since enable
    logic          mode_q;      // mode of the current period
    logic          mode_prev_q; // mode of the previous period
    logic          mclk_q;

    logic [PW-1:0] per_sel;
    logic [CW-1:0] cnt_nx;

    // Decode the requested rate into a period length in system cycles
    always_comb begin
        case (pdm_rate_e'(rate_sel_i))
            RATE_MID:  per_sel = PW'(DIV_MID);
            RATE_FAST: per_sel = PW'(DIV_FAST);
            default:   per_sel = PW'(DIV_SLOW);
        endcase
    end

    assign cnt_nx = cnt_q + CW'(1);

    // Period counter, clock level and per-period latching of rate and mode
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q       <= '0;
            last_q      <= '0;
            half_q      <= '0;
            run_q       <= 1'b0;
            ran_q       <= 1'b0;
            mode_q      <= 1'b0;
            mode_prev_q <= 1'b0;
            mclk_q      <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            ran_q  <= 1'b0;
            mclk_q <= 1'b0;
        end else if (!run_q) begin
            cnt_q       <= '0;
            last_q      <= CW'(per_sel - PW'(1));
            half_q      <= CW'(per_sel >> 1);
            run_q       <= 1'b1;
            ran_q       <= 1'b0;
            mode_q      <= mode_i;
            mode_prev_q <= mode_i;
            mclk_q      <= 1'b1;
        end else if (cnt_q == last_q) begin
            cnt_q       <= '0;
            last_q      <= CW'(per_sel - PW'(1));
            half_q      <= CW'(per_sel >> 1);
            ran_q       <= 1'b1;
            mode_q      <= mode_i;
            mode_prev_q <= mode_q;
            mclk_q      <= 1'b1;
        end else begin
            cnt_q  <= cnt_nx;
            mclk_q <= (cnt_nx < half_q);
        end
    end

    logic rise_cap;
    logic fall_cap;

    // Capture requests, placed CAP_OFS cycles after each microphone clock edge
    always_comb begin
        rise_cap = en_i && run_q && ran_q && (cnt_q == CW'(CAP_OFS));
        fall_cap = en_i && run_q && ran_q && mode_q && mode_prev_q &&
                   (cnt_q == half_q + CW'(CAP_OFS));
        cap_o.left         = rise_cap;
        cap_o.right_split  = rise_cap && !mode_prev_q;
        cap_o.right_shared = fall_cap;
    end

    assign mclk_o = mclk_q;

endmodule

// File: rtl/pdm_mic_capture.sv
// Channel capture registers.
// Loads the synchronized pin bits into the left and right outputs on the
// requests from the clock generator, and raises a one-cycle valid per load.
// Assumes d_i[0] is pin 0 and d_i[1] is pin 1 after synchronization.
module pdm_mic_capture
    import pdm_mic_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  pdm_cap_t   cap_i,
    input  logic [1:0] d_i,
    output logic       left_bit_o,
    output logic       left_vld_o,
    output logic       right_bit_o,
    output logic       right_vld_o
);

    // Left channel: always from pin 0
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            left_bit_o <= 1'b0;
            left_vld_o <= 1'b0;
        end else begin
            left_vld_o <= cap_i.left;
            if (cap_i.left) left_bit_o <= d_i[0];
        end
    end

    // Right channel: pin 1 when the pins are separate, pin 0 when shared
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            right_bit_o <= 1'b0;
            right_vld_o <= 1'b0;
        end else begin
            right_vld_o <= cap_i.right_split | cap_i.right_shared;
            if (cap_i.right_split)       right_bit_o <= d_i[1];
            else if (cap_i.right_shared) right_bit_o <= d_i[0];
        end
    end

endmodule

// File: rtl/pdm_mic_if.sv
// PDM microphone interface top level.
// Ties the data synchronizer, the clock generator and the capture registers
// together. The capture point is moved later by the synchronizer depth, so the
// captured bit is the pin level just before the microphone clock edge.
// Assumes rate_sel_i, mode_mux_i and en_i are synchronous to clk_i.
module pdm_mic_if
    import pdm_mic_pkg::*;
#(
    parameter int DIV_SLOW    = 16,
    parameter int DIV_MID     = 12,
    parameter int DIV_FAST    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       en_i,
    input  logic [1:0] rate_sel_i,
    input  logic       mode_mux_i,
    input  logic       pdm_d0_i,
    input  logic       pdm_d1_i,
    output logic       mclk_o,
    output logic       left_bit_o,
    output logic       left_vld_o,
    output logic       right_bit_o,
    output logic       right_vld_o
);

    localparam int CAP_OFS = SYNC_STAGES - 1;

    logic [1:0] d_sync;
    pdm_cap_t   cap;

    pdm_mic_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     ({pdm_d1_i, pdm_d0_i}),
        .q_o     (d_sync)
    );

    pdm_mic_clkgen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_MID  (DIV_MID),
        .DIV_FAST (DIV_FAST),
        .CAP_OFS  (CAP_OFS)
    ) u_clkgen (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .en_i       (en_i),
        .rate_sel_i (rate_sel_i),
        .mode_i     (mode_mux_i),
        .mclk_o     (mclk_o),
        .cap_o      (cap)
    );

    pdm_mic_capture u_capture (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .cap_i       (cap),
        .d_i         (d_sync),
        .left_bit_o  (left_bit_o),
        .left_vld_o  (left_vld_o),
        .right_bit_o (right_bit_o),
        .right_vld_o (right_vld_o)
    );

endmodule

// File: rtl/pdm_mic_if_chk.sv
// Property checker for pdm_mic_if, attached through bind.
// Observes only top-level ports.
module pdm_mic_if_chk (
    input logic clk_i,
    input logic rst_n_i,
    input logic en_i,
    input logic mclk_o,
    input logic left_vld_o,
    input logic right_vld_o
);

    // R4
    mclk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_i |=> !mclk_o);

    // R4
    strobe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_i |=> !(left_vld_o || right_vld_o));

    // R8
    left_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        left_vld_o |=> !left_vld_o);

    // R8
    right_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        right_vld_o |=> !right_vld_o);

    // R3
    high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($rose(mclk_o) && en_i) |=> mclk_o);

    // R6
    left_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        left_vld_o |-> ($past(mclk_o, 2) && !$past(mclk_o, 3)));

    // R7
    right_shared_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (right_vld_o && !left_vld_o) |-> (!$past(mclk_o, 2) && $past(mclk_o, 3)));

endmodule

bind pdm_mic_if pdm_mic_if_chk u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .en_i        (en_i),
    .mclk_o      (mclk_o),
    .left_vld_o  (left_vld_o),
    .right_vld_o (right_vld_o)
);

// File: tb/pdm_mic_if_test.sv
module pdm_mic_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       mode_mux = 1'b0;
    logic       d0 = 1'b0;
    logic       d1 = 1'b0;
    logic       mclk_o, left_bit_o, left_vld_o, right_bit_o, right_vld_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pdm_mic_if uut (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .en_i        (en),
        .rate_sel_i  (rate_sel),
        .mode_mux_i  (mode_mux),
        .pdm_d0_i    (d0),
        .pdm_d1_i    (d1),
        .mclk_o      (mclk_o),
        .left_bit_o  (left_bit_o),
        .left_vld_o  (left_vld_o),
        .right_bit_o (right_bit_o),
        .right_vld_o (right_vld_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: history of pins and clock, data and strobe-count checks
    bit [7:0] h_m, h_d0, h_d1;
    int       smp = 0;
    bit       prev_m = 1'b0, prev_l = 1'b0, prev_r = 1'b0;
    int       win_l = 0, win_r = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        int i0, i2, i3;
        i0 = smp & 7; i2 = (smp - 2) & 7; i3 = (smp - 3) & 7;
        h_m[i0] = mclk_o;
        if (rst_n) begin
            if (mclk_o && !prev_m) begin win_l = 0; win_r = 0; end
            if (left_vld_o) begin
                win_l++;
                // R6 / R7: left bit from pin 0 just before the rise
                chk(h_d0[i3] == left_bit_o && h_m[i2] && !h_m[i3],
                    "R6 left bit", int'(left_bit_o), int'(h_d0[i3]));
                chk(!prev_l && win_l <= 1, "R8 left strobe", win_l, 1);
            end
            if (right_vld_o) begin
                win_r++;
                if (left_vld_o)   // R6: split pins, right from pin 1
                    chk(h_d1[i3] == right_bit_o, "R6 right bit", int'(right_bit_o), int'(h_d1[i3]));
                else              // R7: shared pin, right just before the fall
                    chk(h_d0[i3] == right_bit_o && !h_m[i2] && h_m[i3],
                        "R7 right bit", int'(right_bit_o), int'(h_d0[i3]));
                chk(!prev_r && win_r <= 1, "R8 right strobe", win_r, 1);
            end
        end
        prev_m = mclk_o; prev_l = left_vld_o; prev_r = right_vld_o;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d0 = lfsr[0]; d1 = lfsr[7];
        h_d0[i0] = d0; h_d1[i0] = d1;
        smp++;
    end

    task automatic wait_rise();
        bit p;
        p = mclk_o;
        forever begin
            @(negedge clk);
            if (mclk_o && !p) break;
            p = mclk_o;
        end
    endtask

    // Starts on a rise sample; ends on the next rise sample
    task automatic measure_from_rise(output int hi, output int lo);
        hi = 1; lo = 0;
        @(negedge clk);
        while (mclk_o) begin hi++; @(negedge clk); end
        while (!mclk_o) begin lo++; @(negedge clk); end
    endtask

    task automatic count_window(input int n, output int l, output int r, output int both);
        l = 0; r = 0; both = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            if (left_vld_o) l++;
            if (right_vld_o) r++;
            if (left_vld_o && right_vld_o) both++;
        end
    endtask

    task automatic restart(input logic [1:0] sel, input logic mode);
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        rate_sel = sel; mode_mux = mode; en = 1'b1;
    endtask

    task automatic test_reset();
        en = 1'b1;
        repeat (4) @(negedge clk);
        // R1
        chk(!mclk_o && !left_vld_o && !right_vld_o, "R1 reset idle",
            int'({mclk_o, left_vld_o, right_vld_o}), 0);
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_rate(input logic [1:0] sel, input int per);
        int hi, lo;
        restart(sel, 1'b0);
        repeat (2 * per) @(negedge clk);
        wait_rise();
        measure_from_rise(hi, lo);
        chk(hi + lo == per, "R2 period", hi + lo, per);
        chk(hi == per / 2 && lo == per / 2, "R3 duty", hi * 100 + lo, (per / 2) * 101);
    endtask

    task automatic test_startup(input logic [1:0] sel, input int per);
        int first_hi, first_v, k;
        @(negedge clk); en = 1'b0;
        repeat (3) @(negedge clk);
        rate_sel = sel; mode_mux = 1'b0; en = 1'b1;
        first_hi = 0; first_v = 0; k = 0;
        while (first_v == 0 && k < 60) begin
            @(negedge clk); k++;
            if (mclk_o && first_hi == 0) first_hi = k;
            if ((left_vld_o || right_vld_o) && first_v == 0) first_v = k;
        end
        chk(first_hi == 1, "R5 clock start", first_hi, 1);
        chk(first_v == per + 3, "R5 first strobe", first_v, per + 3);
    endtask

    task automatic test_disable();
        int bad;
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk(!mclk_o, "R4 clock off", int'(mclk_o), 0);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (mclk_o || left_vld_o || right_vld_o) bad++;
        end
        chk(bad == 0, "R4 idle while disabled", bad, 0);
    endtask

    task automatic test_capture(input logic mode, input logic [1:0] sel, input int per);
        int l, r, both;
        restart(sel, mode);
        repeat (3 * per) @(negedge clk);
        wait_rise();
        count_window(4 * per, l, r, both);
        if (!mode) begin
            chk(l == 4 && r == 4 && both == 4, "R6 split strobes", l * 100 + r * 10 + both, 444);
        end else begin
            chk(l == 4 && r == 4 && both == 0, "R7 shared strobes", l * 100 + r * 10 + both, 440);
        end
    endtask

    task automatic test_rate_change();
        int hi, lo, hi2, lo2;
        restart(2'b00, 1'b0);
        repeat (40) @(negedge clk);
        wait_rise();
        repeat (2) @(negedge clk);
        rate_sel = 2'b10;
        hi = 3; lo = 0;
        @(negedge clk);
        while (mclk_o) begin hi++; @(negedge clk); end
        while (!mclk_o) begin lo++; @(negedge clk); end
        chk(hi == 8 && lo == 8, "R9 current period kept", hi * 100 + lo, 808);
        measure_from_rise(hi2, lo2);
        chk(hi2 == 4 && lo2 == 4, "R9 new rate", hi2 * 100 + lo2, 404);
    endtask

    task automatic test_mode_change();
        int l, r, both;
        restart(2'b10, 1'b0);
        repeat (30) @(negedge clk);
        wait_rise();
        @(negedge clk);
        mode_mux = 1'b1;
        wait_rise();
        count_window(8, l, r, both);
        chk(l == 1 && r == 1 && both == 1, "R10 first shared period", l * 100 + r * 10 + both, 111);
        @(negedge clk);
        count_window(8, l, r, both);
        chk(l == 1 && r == 1 && both == 0, "R10 second shared period", l * 100 + r * 10 + both, 110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_rate(2'b00, 16);
        test_rate(2'b01, 12);
        test_rate(2'b10, 8);
        test_rate(2'b11, 16);
        test_startup(2'b01, 12);
        test_startup(2'b10, 8);
        test_disable();
        test_capture(1'b0, 2'b00, 16);
        test_capture(1'b1, 2'b00, 16);
        test_capture(1'b1, 2'b10, 8);
        test_capture(1'b0, 2'b01, 12);
        test_rate_change();
        test_mode_change();
        test_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule